// File: doc/BRIEF.md
# Interrupt Controller Countdown Timer

A 32-bit down-counter with its own register port, meant to sit beside a local interrupt controller. Software sets up a control word (interrupt vector, mask, one-shot or periodic), picks a clock prescale, then writes a start value. The counter decrements once per prescaled tick. When it reaches zero it emits a one-cycle interrupt pulse carrying the programmed vector, unless masked.

In one-shot mode the counter then rests at zero. In periodic mode it reloads the start value and keeps firing. Writing zero as the start value halts it at once. The live count can be read at any time through the register port. The port takes single-cycle read and write strobes, and read data is returned on the following cycle.

Register selects on `bus_addr`: 0 = control word, 1 = start value, 2 = live count (read-only), 3 = prescale select.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (mask set, one-shot, vector 0), the start value, the live count and the prescale select read 0, and `timer_irq` is low.
- R2: Writing a nonzero start value loads it into the live count and starts counting. Writing one again while counting restarts the count from the new value, and no pulse comes from the abandoned run.
- R3: Writing 0 as the start value stops the counter in the next cycle with a live count of 0, and no pulse follows.
- R4: The prescale select is formed from bits {3,1,0} of the written word. Codes 000 to 110 divide by 2, 4, 8, 16, 32, 64 and 128; code 111 divides by 1. Bit 2 is ignored and reads as 0. The reset code 000 divides by 2.
- R5: With start value N and divisor D, the live count reaches 0 on the N*D-th clock edge after the write edge. `timer_irq` is high for exactly that one cycle, and `timer_vector` carries bits [7:0] of the control word.
- R6: While control bit 16 (mask) is 1, expiry produces no pulse, but counting and stopping are unchanged.
- R7: With control bit 17 at 0 (one-shot), the count holds at 0 after expiry and only one pulse is produced.
- R8: With control bit 17 at 1 (periodic), the count is reloaded with the start value on the cycle after it reaches 0. It then fires again every N*D+1 cycles, and the mode is sampled at each expiry.
- R9: A read of address 2 returns, one cycle later, the live count as it stood at the read edge. Writes to address 2 have no effect.
- R10: The control word reads back the vector in bits [7:0], the mask in bit 16 and the mode in bit 17; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| timer_irq | output | 1 | One-cycle expiry pulse |
| timer_vector | output | 8 | Vector reported with the pulse |

## Verification
The checker tests on every cycle that:
- a pulse lasts a single cycle and only coincides with a zero count;
- a masked entry never pulses;
- the count never rises except by a load or a reload;
- a zero start value halts the counter;
- a periodic zero is followed by the reload value;
- a halted counter stays at zero.

Only the bench scenarios can show the exact expiry cycle for each prescale code, the N*D+1 periodic spacing, and the restart and mid-run mode change behaviour. Those are predicted from the write cycle and compared by the scoreboard.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW       = 2;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam int PS_W         = 7;   // widest prescale count (divide by 128)

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_START  = 2'd1,
    SEL_LIVE   = 2'd2,
    SEL_PRESC  = 2'd3
  } reg_sel_e;

  // Terminal prescale count for a 3-bit code: 111 -> /1, else /(2 << code).
  function automatic logic [PS_W-1:0] presc_last(input logic [2:0] code);
    int v;
    if (code == 3'b111) v = 0;
    else v = (2 << code) - 1;
    return PS_W'(v);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic [CNT_W-1:0]  start_value,
  output logic [DATA_W-1:0] rdata,
  output logic [VEC_W-1:0]  vector,
  output logic              mask,
  output logic              periodic,
  output logic [2:0]        presc_code,
  output logic              start_wr,
  output logic [CNT_W-1:0]  start_data
);
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign start_wr     = wr && (addr == SEL_START);
  assign start_data   = wdata[CNT_W-1:0];

  always_comb begin
    rd_word = '0;
    case (addr)
      SEL_CTRL: begin
        rd_word[VEC_W-1:0]   = vector;
        rd_word[MASK_BIT]     = mask;
        rd_word[PERIODIC_BIT] = periodic;
      end
      SEL_START: rd_word[CNT_W-1:0] = start_value;
      SEL_LIVE:  rd_word[CNT_W-1:0] = live_count;
      default: begin
        rd_word[3]   = presc_code[2];
        rd_word[1:0] = presc_code[1:0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vector     <= '0;
      mask       <= 1'b1;
      periodic   <= 1'b0;
      presc_code <= 3'b000;
      rdata      <= '0;
    end else begin
      if (wr && addr == SEL_CTRL) begin
        vector   <= wdata[VEC_W-1:0];
        mask     <= wdata[MASK_BIT];
        periodic <= wdata[PERIODIC_BIT];
      end
      if (wr && addr == SEL_PRESC)
        presc_code <= {wdata[3], wdata[1:0]};
      if (rd)
        rdata <= rd_word;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] last;

  assign last = presc_last(code);
  assign tick = run && !restart && (ps_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || ps_q == last) ps_q <= '0;
    else                                      ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_data,
  input  logic             tick,
  input  logic             periodic,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] start_value,
  output logic             running,
  output logic             reload_now,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  assign reload_now = running && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      start_value <= '0;
      running     <= 1'b0;
      irq         <= 1'b0;
      irq_vec     <= '0;
    end else begin
      irq <= 1'b0;
      if (start_wr) begin
        start_value <= start_data;
        count       <= start_data;
        running     <= (start_data != '0);
      end else if (reload_now) begin
        count <= start_value;
      end else if (running && tick) begin
        if (count == CNT_W'(1)) begin
          count   <= '0;
          irq     <= !mask;
          irq_vec <= vector;
          running <= periodic;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timer_irq,
  output logic [VEC_W-1:0]  timer_vector
);
  logic [CNT_W-1:0] cur_count;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] icr_val;
  logic [VEC_W-1:0] vec_bits;
  logic [2:0]       presc_code;
  logic             mask_bit, periodic_bit, icr_wr, running, reload_now, tick;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .live_count(cur_count), .start_value(reload_val),
    .rdata(bus_rdata), .vector(vec_bits), .mask(mask_bit),
    .periodic(periodic_bit), .presc_code(presc_code),
    .start_wr(icr_wr), .start_data(icr_val)
  );

  tmr_prescaler u_presc (
    .clk(clk), .rst(rst), .run(running), .restart(icr_wr || reload_now),
    .code(presc_code), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_core (
    .clk(clk), .rst(rst), .start_wr(icr_wr), .start_data(icr_val),
    .tick(tick), .periodic(periodic_bit), .mask(mask_bit), .vector(vec_bits),
    .count(cur_count), .start_value(reload_val), .running(running),
    .reload_now(reload_now), .irq(timer_irq), .irq_vec(timer_vector)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             timer_irq,
  input logic             mask_bit,
  input logic             icr_wr,
  input logic [CNT_W-1:0] icr_val,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] reload_val,
  input logic             running
);
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    timer_irq |=> !timer_irq);

  p_pulse_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> (cur_count == '0));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> !$past(mask_bit));

  p_stop_on_zero_write_r3: assert property (@(posedge clk) disable iff (rst)
    (icr_wr && icr_val == '0) |=> (cur_count == '0 && !running));

  p_reload_after_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (running && cur_count == '0 && !icr_wr) |=> (cur_count == $past(reload_val)));

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!running && cur_count == '0 && !icr_wr) |=> (cur_count == '0 && !timer_irq));

  p_never_rises_r2: assert property (@(posedge clk) disable iff (rst)
    (cur_count != '0 && !icr_wr) |=> (cur_count <= $past(cur_count)));
endmodule

bind irq_countdown_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .timer_irq(timer_irq), .mask_bit(mask_bit),
  .icr_wr(icr_wr), .icr_val(icr_val), .cur_count(cur_count),
  .reload_val(reload_val), .running(running)
);

// File: tb/sim_irq_countdown_timer.sv
module sim_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timer_irq;
  logic [7:0]  timer_vector;

  int n_chk = 0, n_bad = 0, cyc = 0, e0 = 0;
  int    q_cyc[$];
  logic [7:0] q_vec[$];
  string q_tag[$];

  irq_countdown_timer u0 (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every pulse must match the oldest expected item.
  always @(negedge clk) begin
    if (!rst && timer_irq) begin
      if (q_cyc.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5: unexpected pulse at cycle %0d (actual 1 expected 0)", cyc);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " pulse cycle"}, 32'(cyc), 32'(q_cyc.pop_front()));
        check({t, " vector"}, {24'd0, timer_vector}, {24'd0, q_vec.pop_front()});
      end
    end
  end

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
    report();
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    e0 = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  // Live count predicted for a one-shot run started at edge s.
  task automatic rd_live(input string req, input int s, input int n, input int d);
    int r, exp;
    @(negedge clk);
    r = cyc;
    exp = ((r - s) >= n * d) ? 0 : n - (r - s) / d;
    bus_rd = 1'b1; bus_addr = 2'd2;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, 32'(exp));
  endtask

  task automatic expect_irq(input string req, input int at, input logic [7:0] v);
    q_cyc.push_back(at); q_vec.push_back(v); q_tag.push_back(req);
  endtask

  task automatic drain;
    wait (q_cyc.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq idle", {31'd0, timer_irq}, 32'd0);
    rd("R1 ctrl", 2'd0, 32'h0001_0000);
    rd("R1 start", 2'd1, 32'd0);
    rd("R1 live", 2'd2, 32'd0);
    rd("R1 presc", 2'd3, 32'd0);

    // Default /2, one-shot, vector 0x12
    wr(2'd0, 32'h0000_0012);
    wr(2'd1, 32'd3); s = e0;
    expect_irq("R4 default /2", s + 6, 8'h12);
    drain();
    rd_live("R7 hold at zero", s, 3, 2);

    // /1 one-shot, vector 0x21
    wr(2'd3, 32'h0000_000B);
    rd("R4 presc readback", 2'd3, 32'h0000_000B);
    wr(2'd0, 32'h0000_0021);
    wr(2'd1, 32'd5); s = e0;
    expect_irq("R5 /1 one-shot", s + 5, 8'h21);
    drain();
    rd("R2 start readback", 2'd1, 32'd5);
    rd_live("R7 one-shot stays 0", s, 5, 1);

    // /4 with live reads and an ignored write to the live count
    wr(2'd3, 32'h0000_0001);
    wr(2'd1, 32'd3); s = e0;
    expect_irq("R4 /4", s + 12, 8'h21);
    rd_live("R9 live early", s, 3, 4);
    wr(2'd2, 32'h0000_0055);
    rd_live("R9 live after write to live", s, 3, 4);
    rd_live("R9 live later", s, 3, 4);
    drain();

    // /128 via code 110
    wr(2'd3, 32'h0000_000A);
    wr(2'd1, 32'd2); s = e0;
    expect_irq("R4 /128", s + 256, 8'h21);
    drain();

    // Bit 2 ignored: 0xF is code 111 -> /1
    wr(2'd3, 32'h0000_000F);
    rd("R4 reserved bit reads 0", 2'd3, 32'h0000_000B);
    wr(2'd1, 32'd2); s = e0;
    expect_irq("R4 code 111 /1", s + 2, 8'h21);
    drain();

    // Restart while counting: only the second run fires
    wr(2'd1, 32'd10);
    repeat (3) @(negedge clk);
    wr(2'd1, 32'd6); s = e0;
    expect_irq("R2 restart", s + 6, 8'h21);
    drain();

    // Masked: counts to zero, no pulse
    wr(2'd0, 32'h0001_0033);
    wr(2'd1, 32'd4); s = e0;
    repeat (10) @(negedge clk);
    rd_live("R6 masked still counts", s, 4, 1);

    // Periodic /1, N=3: period 4
    wr(2'd0, 32'h0002_0044);
    wr(2'd1, 32'd3); s = e0;
    expect_irq("R8 periodic 1st", s + 3, 8'h44);
    expect_irq("R8 periodic 2nd", s + 7, 8'h44);
    expect_irq("R8 periodic 3rd", s + 11, 8'h44);
    wait (cyc >= s + 12);
    wr(2'd1, 32'd0);
    repeat (12) @(negedge clk);
    rd("R3 stopped live", 2'd2, 32'd0);
    check("R3 queue empty", 32'(q_cyc.size()), 32'd0);

    // Periodic /8, N=2: period 17, then switch to one-shot mid-run
    wr(2'd3, 32'h0000_0002);
    wr(2'd1, 32'd2); s = e0;
    expect_irq("R8 /8 1st", s + 16, 8'h44);
    expect_irq("R8 /8 2nd", s + 33, 8'h44);
    expect_irq("R7 last after mode change", s + 50, 8'h44);
    wait (cyc >= s + 37);
    wr(2'd0, 32'h0000_0044);
    drain();
    repeat (40) @(negedge clk);
    rd("R7 holds after mode change", 2'd2, 32'd0);

    // Control field readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R10 ctrl fields", 2'd0, 32'h0003_00FF);

    check("R5 scoreboard empty", 32'(q_cyc.size()), 32'd0);
    report();
  end
endmodule